// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps the outcome of each finished transmit frame until the host reads it. The transmit engine delivers one strobe per finished frame, together with four result flags. The block stores these as records on a small last-in, first-out stack. The host sees the newest record as a single status byte. Any host write to that byte discards the newest record, so the host keeps reading and writing until the complete bit reads 0.

When the stack is already full, a new record cannot be stored. It is dropped, the overflow bit of the record left on top is set, and a sticky lost-records flag rises. A frame that ended in underrun or jabber leaves the transmitter stuck. The block therefore raises a reset-required flag toward the command unit and holds it until a transmit reset strobe arrives. That strobe also empties the stack and clears the lost flag. The block also emits a one-cycle event pulse for every frame result it is given.

Top module: `txs_stack`

## Requirements
- R1: After the synchronous active-low reset, `host_rd` is 0, and `tx_done`, `need_tx_reset` and `records_lost` are 0.
- R2: A pushed record appears on `host_rd` after the clock edge that takes it. The byte has this layout: bit 7 = 1 (complete), bit 6 = `tx_fin_flags[3]` (interrupt on success), bit 5 = `tx_fin_flags[2]` (jabber), bit 4 = `tx_fin_flags[1]` (underrun), bit 3 = `tx_fin_flags[0]` (maximum collisions), bit 2 = overflow, and bits 1..0 = 0.
- R3: Records are read newest first. After a pop, the record pushed before the popped one is on top.
- R4: Each clock with `host_wr` high removes the top record. A write to an empty stack changes nothing.
- R5: An empty stack reads as 0x00, so the complete bit is 0.
- R6: A push onto a full stack (DEPTH records) with no pop in the same cycle has three effects: the new record is discarded, bit 2 of the top record is set, and `records_lost` goes to 1. The records below the top are not changed.
- R7: A push and a pop in the same cycle on a non-empty stack replace the top record with the new one, and the record count stays the same. On an empty stack, the push is taken and the pop is ignored.
- R8: A pushed record with jabber or underrun set raises `need_tx_reset`, even when the record is dropped. The flag stays high until `tx_reset`, and pops do not clear it.
- R9: `tx_reset` empties the stack and clears `records_lost` and `need_tx_reset`. It takes priority over a push or pop in the same cycle.
- R10: `tx_done` is high for exactly one cycle, in the cycle after each `tx_fin` strobe that does not coincide with `tx_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_fin | input | 1 | Frame finished: push a record |
| tx_fin_flags | input | 4 | {intr-on-success, jabber, underrun, max collisions} |
| host_wr | input | 1 | Host write to the status byte: pop |
| host_rd | output | 8 | Status byte of the top record |
| tx_reset | input | 1 | Transmit reset strobe |
| tx_done | output | 1 | One-cycle event per frame result |
| need_tx_reset | output | 1 | Transmitter needs a transmit reset |
| records_lost | output | 1 | A record was dropped since the last transmit reset |

## Verification
The bench builds the stack with DEPTH set to 3 rather than the default 4. This lets the full-stack cases be reached after three pushes: dropping a record, marking overflow on the top entry, and the same-cycle push and pop at capacity. The shallow depth also keeps the whole drain order observable through a few pops. A behavioural model inside the bench predicts the status byte and the three flags after every cycle, including cycles where a transmit reset coincides with a push or a pop.

// File: rtl/txs_pkg.sv
// Package txs_pkg
// Shared record type and byte packing for the transmit status stack.
// Assumes the status byte layout fixed in the brief (bit 7 complete,
// bit 2 overflow, bits 1..0 zero).
package txs_pkg;

    localparam int FLAG_W = 4;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic intr_req;
        logic jabber;
        logic underrun;
        logic max_coll;
        logic ovf;
    } txs_entry_t;

    // Build a record from the engine flags {intr, jabber, underrun, maxcoll}.
    function automatic txs_entry_t make_entry(input logic [FLAG_W-1:0] f);
        txs_entry_t e;
        e.intr_req = f[3];
        e.jabber   = f[2];
        e.underrun = f[1];
        e.max_coll = f[0];
        e.ovf      = 1'b0;
        return e;
    endfunction

    // Host view of a record; an invalid top reads as zero.
    function automatic logic [BYTE_W-1:0] pack_byte(input logic vld, input txs_entry_t e);
        if (!vld) return '0;
        return {1'b1, e.intr_req, e.jabber, e.underrun, e.max_coll, e.ovf, 2'b00};
    endfunction

endpackage

// File: rtl/txs_lifo.sv
// Module txs_lifo
// Parameterised last-in, first-out store of transmit records.
// Handles append, replace (push with pop), pop, and the overflow mark
// on a full push. Assumes clr is a single-cycle strobe with priority.
module txs_lifo
    import txs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  txs_entry_t push_entry,
    input  logic       pop,
    output logic       top_vld,
    output txs_entry_t top_entry,
    output logic       dropped
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;
    txs_entry_t    mem [DEPTH];
    logic          empty, full;
    logic          do_rep, do_app, do_drop, do_pop;
    int            top_idx;

    // Decode the operation of this cycle.
    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CW'(DEPTH));
        do_rep  = push && pop && !empty && !clr;
        do_app  = push && !do_rep && !full && !clr;
        do_drop = push && !do_rep && full && !clr;
        do_pop  = pop && !push && !empty && !clr;
        top_idx = int'(cnt) - 1;
    end

    assign dropped = do_drop;
    assign top_vld = !empty;

    // Occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (do_app)
            cnt <= cnt + 1'b1;
        else if (do_pop)
            cnt <= cnt - 1'b1;
    end

    // One storage slot per depth position.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic       wr_en;
        txs_entry_t wr_val;

        // Pick the write for this slot.
        always_comb begin
            wr_en  = 1'b0;
            wr_val = mem[i];
            if ((do_rep && i == top_idx) || (do_app && i == int'(cnt))) begin
                wr_en  = 1'b1;
                wr_val = push_entry;
            end else if (do_drop && i == top_idx) begin
                wr_en      = 1'b1;
                wr_val.ovf = 1'b1;
            end
        end

        // Slot register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wr_en)
                mem[i] <= wr_val;
        end
    end

    // Select the top record.
    always_comb begin
        top_entry = '0;
        for (int i = 0; i < DEPTH; i++)
            if (i == top_idx) top_entry = mem[i];
    end

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && full) |=> (cnt == CW'(DEPTH)) && top_entry.ovf);
    p_replace_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clr && !empty) |=> $stable(cnt));
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && !empty) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/txs_flags.sv
// Module txs_flags
// Event pulse, reset-required and lost-record flags of the status stack.
// Assumes push and clr are strobes from the same clock domain.
module txs_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push,
    input  logic fatal_err,
    input  logic dropped,
    output logic done_pulse,
    output logic need_reset,
    output logic lost
);

    // One-cycle event per accepted frame result.
    always_ff @(posedge clk) begin
        if (!rst_n) done_pulse <= 1'b0;
        else        done_pulse <= push && !clr;
    end

    // Sticky transmitter-stuck flag, cleared by transmit reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          need_reset <= 1'b0;
        else if (push && fatal_err) need_reset <= 1'b1;
    end

    // Sticky dropped-record flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) lost <= 1'b0;
        else if (dropped)  lost <= 1'b1;
    end

    p_need_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (need_reset && !clr) |=> need_reset);
    p_need_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fatal_err && !clr) |=> need_reset);
    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |=> done_pulse);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!lost && !need_reset && !done_pulse));

endmodule

// File: rtl/txs_stack.sv
// Module txs_stack
// Transmit completion status stack: frame results pushed by the engine,
// read newest-first and popped by host writes, with overflow marking,
// lost-record and reset-required flags. Synchronous active-low reset.
module txs_stack
    import txs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_fin,
    input  logic [FLAG_W-1:0] tx_fin_flags,
    input  logic              host_wr,
    output logic [BYTE_W-1:0] host_rd,
    input  logic              tx_reset,
    output logic              tx_done,
    output logic              need_tx_reset,
    output logic              records_lost
);

    txs_entry_t new_entry, top_entry;
    logic       top_vld, dropped;

    assign new_entry = make_entry(tx_fin_flags);

    txs_lifo #(.DEPTH(DEPTH)) u_lifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tx_reset),
        .push       (tx_fin),
        .push_entry (new_entry),
        .pop        (host_wr),
        .top_vld    (top_vld),
        .top_entry  (top_entry),
        .dropped    (dropped)
    );

    txs_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tx_reset),
        .push       (tx_fin),
        .fatal_err  (new_entry.jabber || new_entry.underrun),
        .dropped    (dropped),
        .done_pulse (tx_done),
        .need_reset (need_tx_reset),
        .lost       (records_lost)
    );

    // Host byte view of the top record.
    always_comb host_rd = pack_byte(top_vld, top_entry);

    p_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd[1:0] == 2'b00);
    p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd[7] |-> (host_rd == '0));
    p_reset_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> (host_rd == '0));

endmodule

// File: tb/txs_stack_test.sv
module txs_stack_test;
    localparam int DEPTH = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_fin = 1'b0;
    logic [3:0] tx_fin_flags = '0;
    logic       host_wr = 1'b0;
    logic       tx_reset = 1'b0;
    logic [7:0] host_rd;
    logic       tx_done, need_tx_reset, records_lost;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ref_q[$];
    logic ref_need = 1'b0;
    logic ref_lost = 1'b0;

    always #2 clk = ~clk;

    txs_stack #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .tx_fin(tx_fin), .tx_fin_flags(tx_fin_flags),
        .host_wr(host_wr), .host_rd(host_rd), .tx_reset(tx_reset),
        .tx_done(tx_done), .need_tx_reset(need_tx_reset), .records_lost(records_lost)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        return (ref_q.size() == 0) ? 8'h00 : ref_q[ref_q.size()-1];
    endfunction

    // One clock of stimulus, model update and checks at the next falling edge.
    task automatic cyc(input logic p, input logic [3:0] f, input logic w, input logic r, input string req);
        logic [7:0] b;
        @(negedge clk);
        tx_fin = p; tx_fin_flags = f; host_wr = w; tx_reset = r;
        @(negedge clk);
        tx_fin = 0; host_wr = 0; tx_reset = 0;
        b = {1'b1, f, 3'b000};
        if (r) begin
            ref_q.delete(); ref_need = 0; ref_lost = 0;
        end else begin
            if (p && (f[2] || f[1])) ref_need = 1;
            if (p && w && ref_q.size() > 0) ref_q[ref_q.size()-1] = b;
            else if (p && ref_q.size() < DEPTH) ref_q.push_back(b);
            else if (p) begin
                ref_q[ref_q.size()-1][2] = 1'b1; ref_lost = 1;
            end else if (w && ref_q.size() > 0) void'(ref_q.pop_back());
        end
        chk({req, " R10 done"}, {7'd0, tx_done}, {7'd0, p && !r});
        chk({req, " R2 byte"}, host_rd, exp_rd());
        chk({req, " R8 need"}, {7'd0, need_tx_reset}, {7'd0, ref_need});
        chk({req, " R6 lost"}, {7'd0, records_lost}, {7'd0, ref_lost});
    endtask

    task automatic t_reset();
        chk("R1 rd", host_rd, 8'h00);
        chk("R1 flags", {5'd0, tx_done, need_tx_reset, records_lost}, 8'h00);
        chk("R5 empty", {7'd0, host_rd[7]}, 8'h00);
    endtask

    task automatic t_lifo();
        cyc(1, 4'b1000, 0, 0, "R2");
        chk("R2 intr byte", host_rd, 8'hC0);
        cyc(1, 4'b0001, 0, 0, "R3");
        cyc(1, 4'b1001, 0, 0, "R3");
        chk("R3 newest", host_rd, 8'hC8);
        cyc(0, 0, 1, 0, "R4");
        chk("R3 second", host_rd, 8'h88);
        cyc(0, 0, 1, 0, "R4");
        chk("R3 oldest", host_rd, 8'hC0);
        cyc(0, 0, 1, 0, "R4");
        chk("R5 drained", host_rd, 8'h00);
    endtask

    task automatic t_empty_pop();
        cyc(0, 0, 1, 0, "R4 empty pop");
        chk("R4 empty pop", host_rd, 8'h00);
        cyc(1, 4'b0001, 1, 0, "R7 empty push+pop");
        chk("R7 empty push+pop", host_rd, 8'h88);
        cyc(0, 0, 1, 0, "R4");
    endtask

    task automatic t_overflow();
        cyc(1, 4'b0001, 0, 0, "R6 fill");
        cyc(1, 4'b1000, 0, 0, "R6 fill");
        cyc(1, 4'b1001, 0, 0, "R6 fill");
        cyc(1, 4'b0000, 0, 0, "R6 drop");
        chk("R6 top marked", host_rd, 8'hCC);
        chk("R6 lost", {7'd0, records_lost}, 8'h01);
        cyc(1, 4'b0000, 1, 0, "R7 full replace");
        chk("R7 full replace", host_rd, 8'h80);
        cyc(0, 0, 1, 0, "R6 pop");
        chk("R6 below unchanged", host_rd, 8'hC0);
        cyc(0, 0, 1, 0, "R6 pop");
        chk("R6 bottom unchanged", host_rd, 8'h88);
        cyc(0, 0, 0, 1, "R9 clear");
        chk("R9 lost cleared", {7'd0, records_lost}, 8'h00);
    endtask

    task automatic t_need();
        cyc(1, 4'b0010, 0, 0, "R8 underrun");
        chk("R8 underrun", {7'd0, need_tx_reset}, 8'h01);
        cyc(0, 0, 1, 0, "R8 pop keeps");
        chk("R8 pop keeps", {7'd0, need_tx_reset}, 8'h01);
        cyc(0, 0, 0, 1, "R9 reset");
        chk("R9 need cleared", {7'd0, need_tx_reset}, 8'h00);
        cyc(1, 4'b0100, 0, 0, "R8 jabber");
        chk("R8 jabber byte", host_rd, 8'hA0);
        cyc(0, 0, 0, 1, "R9 reset");
    endtask

    task automatic t_reset_priority();
        cyc(1, 4'b0001, 0, 0, "R9 setup");
        cyc(1, 4'b0010, 1, 1, "R9 priority");
        chk("R9 priority empty", host_rd, 8'h00);
        chk("R9 priority need", {7'd0, need_tx_reset}, 8'h00);
        chk("R10 no pulse on reset", {7'd0, tx_done}, 8'h00);
        cyc(1, 4'b0000, 0, 0, "R10 pulse");
        cyc(0, 0, 0, 0, "R10 one cycle");
        chk("R10 one cycle", {7'd0, tx_done}, 8'h00);
    endtask

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lifo();
        t_empty_pop();
        t_overflow();
        t_need();
        t_reset_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule